// File: doc/BRIEF.md
# Release-On-Acknowledge Bus Interrupter

This block raises one interrupt request on a shared system bus. Software writes a small level code into a request register. A nonzero code pulls the matching active-low request line low, and every other line stays high. A code of zero means nothing is requested.

The bus controller runs an interrupt acknowledge cycle by presenting a level and a strobe. If that level equals the pending request, the block answers the cycle. It then clears its own register and lets the line go, so software never has to withdraw a request it has already made. An acknowledge at any other level is ignored. A write that lands in the same cycle as a matching acknowledge wins, and the newly written level is loaded. The active-low asynchronous system reset clears the register.

Top module: `bus_interrupter`

## Requirements
- R1: After reset the level reads 0, all request lines are high and the answer pulse `ack_hit_o` is low.
- R2: One cycle after a write of a nonzero level N, line N is low and every other line is high. Line N appears on bit N-1 of `irq_no_o`.
- R3: A write of 0 releases every line in the following cycle.
- R4: A matching acknowledge is one where the strobe is high, the acknowledged level equals the nonzero pending level, and there is no write in that cycle. One cycle after it is sampled, the level reads 0, all lines are high, and `ack_hit_o` is high for exactly that one cycle.
- R5: An acknowledge whose level differs from the pending level has no effect on the level, the lines or `ack_hit_o`. This includes an acknowledge at level 0 while no request is pending.
- R6: When a write and a matching acknowledge arrive in the same cycle, the written level is loaded and the request stays active at that level.
- R7: `rd_data_o` always returns the current level, including 0 after an automatic clear.
- R8: At most one request line is low at any time.
- R9: Rewriting a different nonzero level while a request is pending moves the request to the new line in the next cycle, and the old line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 3 | Level to write (0 = no request) |
| rd_data_o | output | 3 | Current level |
| ack_cyc_i | input | 1 | Interrupt acknowledge strobe |
| ack_lvl_i | input | 3 | Level being acknowledged |
| ack_hit_o | output | 1 | One-cycle pulse: this block answered the acknowledge |
| irq_no_o | output | 7 | Active-low request lines; bit N-1 is level N |

## Verification
The bench writes level 1, level 7 and an interior level. These writes show that the decode reaches both ends of the line vector and lowers only one line at a time. Acknowledges are issued at the pending level, at a different level, and at level 0 while idle. Together they separate a true match from a stray acknowledge and from the idle case. A write colliding with a matching acknowledge, and a rewrite to a different level, show whether the write takes priority over the automatic clear.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned DEF_NUM_LVL = 7;

  function automatic int unsigned lvl_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/intr_ack_match.sv
module intr_ack_match #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             ack_cyc_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  output logic             match_o
);
  always_comb begin
    match_o = ack_cyc_i && (cur_lvl_i != '0) && (ack_lvl_i == cur_lvl_i);
  end
endmodule

// File: rtl/intr_lvl_reg.sv
module intr_lvl_reg #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [LVL_W-1:0] wr_data_i,
  input  logic             match_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             hit_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      hit_q <= 1'b0;
    end else begin
      // write wins over release-on-acknowledge
      if (wr_en_i)      lvl_q <= wr_data_i;
      else if (match_i) lvl_q <= '0;
      hit_q <= match_i && !wr_en_i;
    end
  end

  assign lvl_o = lvl_q;
  assign hit_o = hit_q;
endmodule

// File: rtl/intr_irq_decode.sv
module intr_irq_decode #(
  parameter int unsigned NUM_LVL = 7,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [NUM_LVL-1:0] irq_no_o
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
    assign irq_no_o[g] = (lvl_i != LVL_W'(g + 1));
  end
endmodule

// File: rtl/bus_interrupter.sv
module bus_interrupter #(
  parameter int unsigned NUM_LVL = intr_pkg::DEF_NUM_LVL,
  localparam int unsigned LVL_W  = intr_pkg::lvl_width(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [LVL_W-1:0]   wr_data_i,
  output logic [LVL_W-1:0]   rd_data_o,
  input  logic               ack_cyc_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  output logic               ack_hit_o,
  output logic [NUM_LVL-1:0] irq_no_o
);
  logic [LVL_W-1:0] lvl;
  logic             match;

  intr_ack_match #(.LVL_W(LVL_W)) u_match (
    .ack_cyc_i (ack_cyc_i),
    .ack_lvl_i (ack_lvl_i),
    .cur_lvl_i (lvl),
    .match_o   (match)
  );

  intr_lvl_reg #(.LVL_W(LVL_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .match_i   (match),
    .lvl_o     (lvl),
    .hit_o     (ack_hit_o)
  );

  intr_irq_decode #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_dec (
    .lvl_i    (lvl),
    .irq_no_o (irq_no_o)
  );

  assign rd_data_o = lvl;
endmodule

// File: rtl/bus_interrupter_chk.sv
module bus_interrupter_chk #(
  parameter int unsigned NUM_LVL = 7,
  parameter int unsigned LVL_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [LVL_W-1:0]   wr_data_i,
  input logic [LVL_W-1:0]   rd_data_o,
  input logic               ack_cyc_i,
  input logic [LVL_W-1:0]   ack_lvl_i,
  input logic               ack_hit_o,
  input logic [NUM_LVL-1:0] irq_no_o
);
  AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~irq_no_o) <= 1); // R8

  AST_LINE_FOLLOWS_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o != '0) |-> !irq_no_o[rd_data_o - 1'b1]); // R2

  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_cyc_i && !wr_en_i && rd_data_o != '0 && ack_lvl_i == rd_data_o)
    |=> (rd_data_o == '0 && (&irq_no_o) && ack_hit_o)); // R4

  AST_MISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && (!ack_cyc_i || ack_lvl_i != rd_data_o))
    |=> ($stable(rd_data_o) && !ack_hit_o)); // R5

  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o == $past(wr_data_i))); // R6

  AST_HIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit_o |=> !ack_hit_o || $past(ack_cyc_i)); // R4
endmodule

bind bus_interrupter bus_interrupter_chk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .ack_cyc_i (ack_cyc_i),
  .ack_lvl_i (ack_lvl_i),
  .ack_hit_o (ack_hit_o),
  .irq_no_o  (irq_no_o)
);

// File: tb/sim_bus_interrupter.sv
module sim_bus_interrupter;
  localparam int unsigned NL = 7;
  localparam int unsigned LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [LW-1:0] wr_data = '0;
  logic [LW-1:0] rd_data;
  logic          ack_cyc = 1'b0;
  logic [LW-1:0] ack_lvl = '0;
  logic          ack_hit;
  logic [NL-1:0] irq_n;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_interrupter #(.NUM_LVL(NL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ack_cyc_i(ack_cyc), .ack_lvl_i(ack_lvl),
    .ack_hit_o(ack_hit), .irq_no_o(irq_n)
  );

  function automatic logic [NL-1:0] exp_lines(input int lvl);
    logic [NL-1:0] v = '1;
    if (lvl != 0) v[lvl-1] = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input int lvl, input logic hit);
    n_run++;
    if (rd_data !== LW'(lvl) || irq_n !== exp_lines(lvl) || ack_hit !== hit) begin
      n_fail++;
      $display("FAIL %s: lvl=%0d lines=%b hit=%b expected lvl=%0d lines=%b hit=%b",
               req, rd_data, irq_n, ack_hit, lvl, exp_lines(lvl), hit);
    end
  endtask

  // one-cycle stimulus; outputs sampled at the following negedge
  task automatic step(input logic we, input int wd, input logic ac, input int al);
    @(negedge clk);
    wr_en = we; wr_data = LW'(wd); ack_cyc = ac; ack_lvl = LW'(al);
    @(negedge clk);
    wr_en = 1'b0; ack_cyc = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", 0, 1'b0);
  endtask

  task automatic t_write_levels;
    step(1, 1, 0, 0); check("R2 lvl1", 1, 1'b0);
    step(1, 7, 0, 0); check("R9 move to 7", 7, 1'b0);
    step(1, 4, 0, 0); check("R9 move to 4", 4, 1'b0);
    step(1, 0, 0, 0); check("R3 withdraw", 0, 1'b0);
  endtask

  task automatic t_ack_match;
    step(1, 5, 0, 0); check("R2 lvl5", 5, 1'b0);
    step(0, 0, 1, 5); check("R4 release", 0, 1'b1);
    @(negedge clk);   check("R4 pulse ends", 0, 1'b0);
    check("R7 read 0 after clear", 0, 1'b0);
  endtask

  task automatic t_ack_miss;
    step(1, 3, 0, 0); check("R2 lvl3", 3, 1'b0);
    step(0, 0, 1, 2); check("R5 other level", 3, 1'b0);
    step(0, 0, 1, 0); check("R5 level 0 ack", 3, 1'b0);
    step(1, 0, 0, 0); check("R3 clear", 0, 1'b0);
    step(0, 0, 1, 0); check("R5 idle ack 0", 0, 1'b0);
  endtask

  task automatic t_collide;
    step(1, 6, 0, 0); check("R7 read 6", 6, 1'b0);
    step(1, 2, 1, 6); check("R6 write wins", 2, 1'b0);
    step(0, 0, 1, 2); check("R4 ack after collide", 0, 1'b1);
  endtask

  task automatic t_reset_mid;
    step(1, 7, 0, 0); check("R2 lvl7", 7, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1; check("R1 async reset", 0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_levels();
    t_ack_match();
    t_ack_miss();
    t_collide();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule